// File: doc/BRIEF.md
# Ticket-Locked Shared FIFO Stream Sequencer

This block serves one channel of a coprocessor. It moves an endless stream of 32-bit words between the coprocessor and a circular FIFO in shared memory. Other agents can reach the same FIFO, so every exchange takes place under a queuing ticket lock. Each pass of the sequence runs in this order:

1. Take a ticket, using a read followed by a compare-and-swap.
2. Poll the now-serving word until it shows the ticket just taken.
3. Read the three-word FIFO descriptor.
4. Move one burst to or from the coprocessor, but only when the FIFO holds enough data or has enough room for it.
5. Write the descriptor back.
6. Hand the lock to the next ticket holder.

The block repeats this pass for as long as its run input is held high.

Memory is reached through a simple packet initiator port. The block sends one request flit per handshake, each flit carrying a command, an address, write data, a compare value and a last-flit flag. Responses come back one word per handshake. A read returns one response word per flit. A write packet returns one acknowledge word. A compare-and-swap returns the value memory held before the operation. The coprocessor side uses valid/ready word ports: one carries words towards the coprocessor and one carries words from it.

Top module: `mwmr_seq`

## Requirements
- R1: After reset, and while `runEn` stays low, the block issues no request and asserts neither `toValid` nor `fromReady`.
- R2: A pass starts with a one-flit READ (command 0) of the ticket word at `lockAddr`. This is followed by a one-flit CAS (command 2) at `lockAddr` with `reqCmpData` equal to the ticket read and `reqWdata` equal to that ticket plus one.
- R3: When the CAS response differs from `reqCmpData`, the CAS has failed and the pass restarts at the ticket read.
- R4: The block reads the now-serving word at `lockAddr+4` with one-flit READs. It repeats the read until the value returned equals the owned ticket.
- R5: The descriptor is read as one 3-flit READ from `descAddr`. Word 0 is the read offset, word 1 is the write offset and word 2 is the fill level, all in bytes.
- R6: With `toCoproc`=1 and a fill level of at least one burst (4·`BURST_WORDS` bytes), the block issues a `BURST_WORDS`-flit READ from `bufAddr`+read offset. The response words go to the coprocessor in order, and each word is held until `toReady` accepts it.
- R7: With `toCoproc`=0 and free space (`bufSize` minus fill) of at least one burst, the block issues a `BURST_WORDS`-flit WRITE (command 1) to `bufAddr`+write offset. Each flit carries the next coprocessor word and consumes it from the from-coprocessor port.
- R8: When the FIFO lacks one burst of data (`toCoproc`=1) or of space (`toCoproc`=0), the block moves no data, leaves the descriptor unwritten and goes straight to the lock release.
- R9: After a transfer, the block writes the descriptor back as a 3-flit WRITE. The offset used advances by one burst and wraps to zero on reaching `bufSize`. The fill level falls by one burst on a read and rises by one burst on a write.
- R10: The lock release is a one-flit WRITE of the owned ticket plus one to `lockAddr+4`.
- R11: `runEn` is sampled only between passes. A pass that has started always runs to its release, and the passes keep repeating while `runEn` is high.
- R12: While a request flit waits for `reqReady`, its command and address are held steady. No response is accepted while a packet is still being sent, and the next packet starts only after all responses to the previous one have arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstn | input | 1 | Active-low synchronous reset |
| runEn | input | 1 | Keep running passes |
| toCoproc | input | 1 | 1: memory to coprocessor, 0: coprocessor to memory |
| lockAddr | input | ADDR_W | Ticket word address; the now-serving word sits at +4 |
| descAddr | input | ADDR_W | Descriptor base address |
| bufAddr | input | ADDR_W | FIFO buffer base address |
| bufSize | input | 32 | FIFO buffer size in bytes, a multiple of the burst size |
| reqValid | output | 1 | Request flit valid |
| reqReady | input | 1 | Request flit accepted |
| reqCmd | output | 2 | 0 READ, 1 WRITE, 2 CAS |
| reqAddr | output | ADDR_W | Flit byte address |
| reqWdata | output | 32 | Write data, or the CAS new value |
| reqCmpData | output | 32 | CAS compare value (the owned ticket) |
| reqLast | output | 1 | Last flit of the packet |
| rspValid | input | 1 | Response word valid |
| rspReady | output | 1 | Response word accepted |
| rspData | input | 32 | Response word |
| toValid | output | 1 | Word towards the coprocessor is valid |
| toReady | input | 1 | Coprocessor accepts the word |
| toData | output | 32 | Word towards the coprocessor |
| fromValid | input | 1 | Coprocessor offers a word |
| fromReady | output | 1 | Offered word is taken |
| fromData | input | 32 | Word from the coprocessor |

## Verification
Request flits and coprocessor handshakes are combinational from the sequencer state, so each one is due in the same cycle as the state that enables it. A response accepted at one edge moves the sequence into its next step at that edge, and the next request can appear in the following cycle. Memory effects such as the ticket, the serving word and the descriptor can only be judged once the release has been acknowledged. For that reason the bench drives every input at the falling edge, records the handshakes one time unit later, applies their memory effects at the next falling edge, and compares memory only after the release response plus a quiet tail. Ready and valid are throttled with unrelated cycle patterns, so every hold-while-stalled path is exercised.

// File: rtl/mwmr_seq_pkg.sv
package mwmr_seq_pkg;
  localparam int IDX_W = 8;

  typedef enum logic [1:0] {
    CMD_READ  = 2'd0,
    CMD_WRITE = 2'd1,
    CMD_CAS   = 2'd2
  } cmd_e;

  typedef enum logic [2:0] {
    ST_TICKET, ST_CAS, ST_LOCK, ST_DESC, ST_DATA, ST_UPD, ST_REL
  } step_e;

  typedef struct packed {
    step_e             step;
    logic [IDX_W-1:0]  idx;
    logic              capTicket;
    logic              capDesc;
    logic              commit;
  } seq_ctl_t;
endpackage

// File: rtl/mwmr_seq_ctrl.sv
module mwmr_seq_ctrl
  import mwmr_seq_pkg::*;
#(
  parameter int BURST_WORDS = 4
) (
  input  logic     clk,
  input  logic     rstn,
  input  logic     runEn,
  input  logic     toCoproc,
  input  logic     reqReady,
  input  logic     rspValid,
  input  logic     fromValid,
  input  logic     toReady,
  input  logic     ticketMatch,
  input  logic     haveRoom,
  output logic     reqValid,
  output logic     reqLast,
  output logic     rspReady,
  output logic     toValid,
  output logic     fromReady,
  output seq_ctl_t ctl
);
  logic             busy, inRsp;
  step_e            step;
  logic [IDX_W-1:0] cnt;
  logic [IDX_W-1:0] reqLen, rspLen;
  logic             dataWr, dataRd, reqFire, rspFire, rspLastFire;

  always_comb begin
    unique case (step)
      ST_DESC, ST_UPD: reqLen = IDX_W'(3);
      ST_DATA:         reqLen = IDX_W'(BURST_WORDS);
      default:         reqLen = IDX_W'(1);
    endcase
    unique case (step)
      ST_DESC: rspLen = IDX_W'(3);
      ST_DATA: rspLen = toCoproc ? IDX_W'(BURST_WORDS) : IDX_W'(1);
      default: rspLen = IDX_W'(1);
    endcase
  end

  assign dataWr      = (step == ST_DATA) && !toCoproc;
  assign dataRd      = busy && inRsp && (step == ST_DATA) && toCoproc;
  assign reqValid    = busy && !inRsp && (!dataWr || fromValid);
  assign fromReady   = busy && !inRsp && dataWr && reqReady;
  assign reqFire     = reqValid && reqReady;
  assign reqLast     = (cnt == reqLen - IDX_W'(1));
  assign rspReady    = busy && inRsp && (dataRd ? toReady : 1'b1);
  assign toValid     = dataRd && rspValid;
  assign rspFire     = rspValid && rspReady;
  assign rspLastFire = rspFire && (cnt == rspLen - IDX_W'(1));

  always_comb begin
    ctl.step      = step;
    ctl.idx       = cnt;
    ctl.capTicket = rspFire && (step == ST_TICKET);
    ctl.capDesc   = rspFire && (step == ST_DESC);
    ctl.commit    = rspLastFire && (step == ST_DATA);
  end

  always_ff @(posedge clk) begin
    if (!rstn) begin
      busy  <= 1'b0;
      inRsp <= 1'b0;
      step  <= ST_TICKET;
      cnt   <= '0;
    end else if (!busy) begin
      if (runEn) begin
        busy  <= 1'b1;
        inRsp <= 1'b0;
        step  <= ST_TICKET;
        cnt   <= '0;
      end
    end else if (!inRsp) begin
      if (reqFire) begin
        if (reqLast) begin
          inRsp <= 1'b1;
          cnt   <= '0;
        end else begin
          cnt <= cnt + IDX_W'(1);
        end
      end
    end else if (rspFire) begin
      if (!rspLastFire) begin
        cnt <= cnt + IDX_W'(1);
      end else begin
        cnt   <= '0;
        inRsp <= 1'b0;
        unique case (step)
          ST_TICKET: step <= ST_CAS;
          ST_CAS:    step <= ticketMatch ? ST_LOCK : ST_TICKET;
          ST_LOCK:   step <= ticketMatch ? ST_DESC : ST_LOCK;
          ST_DESC:   step <= haveRoom ? ST_DATA : ST_REL;
          ST_DATA:   step <= ST_UPD;
          ST_UPD:    step <= ST_REL;
          default: begin
            step <= ST_TICKET;
            busy <= 1'b0;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/mwmr_seq_dp.sv
module mwmr_seq_dp
  import mwmr_seq_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int BURST_WORDS = 4
) (
  input  logic              clk,
  input  logic              rstn,
  input  seq_ctl_t          ctl,
  input  logic              toCoproc,
  input  logic [ADDR_W-1:0] lockAddr,
  input  logic [ADDR_W-1:0] descAddr,
  input  logic [ADDR_W-1:0] bufAddr,
  input  logic [31:0]       bufSize,
  input  logic [31:0]       rspData,
  input  logic [31:0]       fromData,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [1:0]        reqCmd,
  output logic [31:0]       reqWdata,
  output logic [31:0]       reqCmpData,
  output logic              ticketMatch,
  output logic              haveRoom
);
  localparam logic [31:0] BURST_BYTES = 32'(4 * BURST_WORDS);

  logic [31:0]       ticket, rdPtr, wrPtr, fill, fillNow, ptrSel;
  logic [ADDR_W-1:0] wordOff;
  cmd_e              cmd;

  function automatic logic [31:0] wrapAdd(input logic [31:0] p, input logic [31:0] sz);
    logic [31:0] s;
    s = p + BURST_BYTES;
    return (s >= sz) ? s - sz : s;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstn) begin
      ticket <= '0;
      rdPtr  <= '0;
      wrPtr  <= '0;
      fill   <= '0;
    end else begin
      if (ctl.capTicket) ticket <= rspData;
      if (ctl.capDesc) begin
        unique case (ctl.idx)
          IDX_W'(0): rdPtr <= rspData;
          IDX_W'(1): wrPtr <= rspData;
          default:   fill  <= rspData;
        endcase
      end
      if (ctl.commit) begin
        if (toCoproc) begin
          rdPtr <= wrapAdd(rdPtr, bufSize);
          fill  <= fill - BURST_BYTES;
        end else begin
          wrPtr <= wrapAdd(wrPtr, bufSize);
          fill  <= fill + BURST_BYTES;
        end
      end
    end
  end

  assign fillNow     = (ctl.capDesc && ctl.idx == IDX_W'(2)) ? rspData : fill;
  assign haveRoom    = toCoproc ? (fillNow >= BURST_BYTES) : ((bufSize - fillNow) >= BURST_BYTES);
  assign ticketMatch = (rspData == ticket);
  assign reqCmpData  = ticket;
  assign ptrSel      = toCoproc ? rdPtr : wrPtr;
  assign wordOff     = ADDR_W'({ctl.idx, 2'b00});
  assign reqCmd      = cmd;

  always_comb begin
    cmd      = CMD_READ;
    reqAddr  = lockAddr;
    reqWdata = '0;
    unique case (ctl.step)
      ST_TICKET: ;
      ST_CAS: begin
        cmd      = CMD_CAS;
        reqWdata = ticket + 32'd1;
      end
      ST_LOCK: reqAddr = lockAddr + ADDR_W'(4);
      ST_DESC: reqAddr = descAddr + wordOff;
      ST_DATA: begin
        cmd      = toCoproc ? CMD_READ : CMD_WRITE;
        reqAddr  = bufAddr + ADDR_W'(ptrSel) + wordOff;
        reqWdata = fromData;
      end
      ST_UPD: begin
        cmd     = CMD_WRITE;
        reqAddr = descAddr + wordOff;
        unique case (ctl.idx)
          IDX_W'(0): reqWdata = rdPtr;
          IDX_W'(1): reqWdata = wrPtr;
          default:   reqWdata = fill;
        endcase
      end
      default: begin
        cmd      = CMD_WRITE;
        reqAddr  = lockAddr + ADDR_W'(4);
        reqWdata = ticket + 32'd1;
      end
    endcase
  end
endmodule

// File: rtl/mwmr_seq.sv
module mwmr_seq
  import mwmr_seq_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int BURST_WORDS = 4
) (
  input  logic              clk,
  input  logic              rstn,
  input  logic              runEn,
  input  logic              toCoproc,
  input  logic [ADDR_W-1:0] lockAddr,
  input  logic [ADDR_W-1:0] descAddr,
  input  logic [ADDR_W-1:0] bufAddr,
  input  logic [31:0]       bufSize,
  output logic              reqValid,
  input  logic              reqReady,
  output logic [1:0]        reqCmd,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [31:0]       reqWdata,
  output logic [31:0]       reqCmpData,
  output logic              reqLast,
  input  logic              rspValid,
  output logic              rspReady,
  input  logic [31:0]       rspData,
  output logic              toValid,
  input  logic              toReady,
  output logic [31:0]       toData,
  input  logic              fromValid,
  output logic              fromReady,
  input  logic [31:0]       fromData
);
  seq_ctl_t ctl;
  logic     ticketMatch, haveRoom;

  mwmr_seq_ctrl #(.BURST_WORDS(BURST_WORDS)) u_ctrl (
    .clk(clk), .rstn(rstn), .runEn(runEn), .toCoproc(toCoproc),
    .reqReady(reqReady), .rspValid(rspValid), .fromValid(fromValid),
    .toReady(toReady), .ticketMatch(ticketMatch), .haveRoom(haveRoom),
    .reqValid(reqValid), .reqLast(reqLast), .rspReady(rspReady),
    .toValid(toValid), .fromReady(fromReady), .ctl(ctl)
  );

  mwmr_seq_dp #(.ADDR_W(ADDR_W), .BURST_WORDS(BURST_WORDS)) u_dp (
    .clk(clk), .rstn(rstn), .ctl(ctl), .toCoproc(toCoproc),
    .lockAddr(lockAddr), .descAddr(descAddr), .bufAddr(bufAddr),
    .bufSize(bufSize), .rspData(rspData), .fromData(fromData),
    .reqAddr(reqAddr), .reqCmd(reqCmd), .reqWdata(reqWdata),
    .reqCmpData(reqCmpData), .ticketMatch(ticketMatch), .haveRoom(haveRoom)
  );

  assign toData = rspData;
endmodule

// File: rtl/mwmr_seq_chk.sv
module mwmr_seq_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstn,
  input logic [ADDR_W-1:0] lockAddr,
  input logic              reqValid,
  input logic              reqReady,
  input logic [1:0]        reqCmd,
  input logic [ADDR_W-1:0] reqAddr,
  input logic [31:0]       reqWdata,
  input logic [31:0]       reqCmpData,
  input logic              rspValid,
  input logic              rspReady,
  input logic              toValid,
  input logic              toReady,
  input logic              fromValid,
  input logic              fromReady,
  input logic [31:0]       fromData
);
  // R12
  hold_req_chk: assert property (@(posedge clk) disable iff (!rstn)
    reqValid && !reqReady |=> reqAddr == $past(reqAddr) && reqCmd == $past(reqCmd));

  // R12
  one_way_chk: assert property (@(posedge clk) disable iff (!rstn)
    reqValid |-> !rspReady);

  // R2
  cas_form_chk: assert property (@(posedge clk) disable iff (!rstn)
    reqValid && reqCmd == 2'd2 |-> reqAddr == lockAddr && reqWdata == reqCmpData + 32'd1);

  // R10
  release_chk: assert property (@(posedge clk) disable iff (!rstn)
    reqValid && reqCmd == 2'd1 && reqAddr == lockAddr + ADDR_W'(4) |-> reqWdata == reqCmpData + 32'd1);

  // R6
  to_path_chk: assert property (@(posedge clk) disable iff (!rstn)
    toValid |-> rspValid && rspReady == toReady);

  // R7
  from_path_chk: assert property (@(posedge clk) disable iff (!rstn)
    fromValid && fromReady |-> reqValid && reqReady && reqCmd == 2'd1 && reqWdata == fromData);
endmodule

bind mwmr_seq mwmr_seq_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_mwmr_seq.sv
module sim_mwmr_seq;
  logic        clk = 0, rstn = 0, runEn = 0, toCoproc = 0;
  logic [31:0] lockAddr = 32'h00, descAddr = 32'h10, bufAddr = 32'h40, bufSize = 32'd32;
  logic        reqValid, reqReady = 0, reqLast, rspReady, toValid, toReady = 0, fromReady;
  logic        rspValid = 0, fromValid = 0;
  logic [1:0]  reqCmd;
  logic [31:0] reqAddr, reqWdata, reqCmpData, toData, rspData = 0, fromData = 0;

  mwmr_seq u0 (.*);

  always #2 clk = ~clk;

  int total = 0, bad = 0, cyc = 0;
  logic [31:0] mem [0:63];
  logic [31:0] rq [0:15];
  int head = 0, tail = 0;
  logic pReq = 0, pRsp = 0, pTo = 0, pFrom = 0;
  logic [1:0]  pCmd;
  logic [31:0] pAddr, pWd, pCmp, pToData;
  logic        pLast;
  int casCnt, lockRds, descRds, bufFlits, relCnt, nTo, fromCnt, lateReqs;
  logic forceFail, contend;
  logic [31:0] rx [0:7];

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic memOp();
    int w;
    logic [31:0] old;
    w = int'(pAddr >> 2);
    if (pAddr >= 32'h40) bufFlits++;
    if (pCmd == 2'd0) begin
      rq[tail % 16] = mem[w]; tail++;
      if (pAddr == 32'h4) begin
        lockRds++;
        if (contend && lockRds == 3) mem[1] = mem[1] + 1;
      end
      if (pAddr >= 32'h10 && pAddr < 32'h20) descRds++;
    end else if (pCmd == 2'd1) begin
      mem[w] = pWd;
      if (pLast) begin rq[tail % 16] = 32'h0; tail++; end
      if (pAddr == 32'h4) relCnt++;
    end else begin
      casCnt++;
      if (forceFail) begin mem[w] = mem[w] + 1; forceFail = 0; end
      old = mem[w];
      if (old == pCmp) mem[w] = pWd;
      rq[tail % 16] = old; tail++;
    end
  endtask

  task automatic tick();
    @(negedge clk);
    if (pReq) memOp();
    if (pRsp) head++;
    if (pTo && nTo < 8) begin rx[nTo] = pToData; nTo++; end
    if (pFrom) fromCnt++;
    cyc++;
    reqReady  = (cyc % 3) != 0;
    rspValid  = (head != tail) && ((cyc % 4) != 1);
    rspData   = rq[head % 16];
    toReady   = (cyc % 5) != 2;
    fromValid = (cyc % 2) == 0;
    fromData  = 32'hB000 + 32'(fromCnt);
    #1;
    pReq = reqValid && reqReady; pCmd = reqCmd; pAddr = reqAddr; pWd = reqWdata;
    pCmp = reqCmpData; pLast = reqLast;
    pRsp = rspValid && rspReady;
    pTo = toValid && toReady; pToData = toData;
    pFrom = fromValid && fromReady;
  endtask

  // mode 0 plain, 1 lock contention, 2 failed CAS, 3 two passes
  task automatic runPass(input logic dir, input int rp, input int fill, input int mode);
    int myT, passes, guard, wp, nrp, nwp, nfill;
    logic room;
    for (int i = 0; i < 64; i++) mem[i] = 32'h0;
    for (int i = 0; i < 8; i++) mem[16 + i] = 32'hA000 + 32'(i);
    wp = (rp + fill) % 32;
    mem[0] = 5;
    mem[1] = (mode == 1) ? 4 : (mode == 2) ? 6 : 5;
    mem[4] = rp; mem[5] = wp; mem[6] = fill;
    casCnt = 0; lockRds = 0; descRds = 0; bufFlits = 0; relCnt = 0; nTo = 0; fromCnt = 0; lateReqs = 0;
    forceFail = (mode == 2); contend = (mode == 1);
    passes = (mode == 3) ? 2 : 1;
    toCoproc = dir; runEn = 1; guard = 0;
    while (relCnt < passes || head != tail) begin
      tick();
      if (pReq && relCnt >= passes - 1) runEn = 0;
      guard++;
      if (guard > 4000) begin
        chk(1'b0, "R11 watchdog", 32'(guard), 32'd4000);
        break;
      end
    end
    repeat (20) begin tick(); if (pReq) lateReqs++; end
    myT = (mode == 2 || mode == 3) ? 6 : 5;
    chk(lateReqs == 0, "R11 stop when run low", 32'(lateReqs), 0);
    chk(mem[0] == 32'(myT + 1), "R2 ticket taken", mem[0], 32'(myT + 1));
    chk(mem[1] == 32'(myT + 1), "R10 release value", mem[1], 32'(myT + 1));
    chk(casCnt == ((mode >= 2) ? 2 : 1), "R3 CAS count", 32'(casCnt), (mode >= 2) ? 2 : 1);
    chk(descRds == 3 * passes, "R5 descriptor reads", 32'(descRds), 32'(3 * passes));
    chk(head == tail, "R12 responses drained", 32'(head), 32'(tail));
    if (mode == 1) chk(lockRds == 4, "R4 lock polling", 32'(lockRds), 4);
    if (mode == 3) begin
      chk(mem[4] == 0 && mem[6] == 0, "R9 wrap over two passes", mem[4], 0);
      chk(nTo == 8, "R11 two passes moved data", 32'(nTo), 8);
    end else begin
      room = dir ? (fill >= 16) : (32 - fill >= 16);
      if (room) begin
        nrp = dir ? (rp + 16) % 32 : rp;
        nwp = dir ? wp : (wp + 16) % 32;
        nfill = dir ? fill - 16 : fill + 16;
        chk(mem[4] == 32'(nrp), "R9 read offset", mem[4], 32'(nrp));
        chk(mem[5] == 32'(nwp), "R9 write offset", mem[5], 32'(nwp));
        chk(mem[6] == 32'(nfill), "R9 fill level", mem[6], 32'(nfill));
        for (int k = 0; k < 4; k++) begin
          if (dir) chk(nTo == 4 && rx[k] == 32'hA000 + 32'(rp / 4 + k), "R6 word to coprocessor", rx[k], 32'hA000 + 32'(rp / 4 + k));
          else chk(mem[16 + wp / 4 + k] == 32'hB000 + 32'(k), "R7 word from coprocessor", mem[16 + wp / 4 + k], 32'hB000 + 32'(k));
        end
      end else begin
        chk(bufFlits == 0 && nTo == 0 && fromCnt == 0, "R8 no data moved", 32'(bufFlits + nTo + fromCnt), 0);
        chk(mem[4] == 32'(rp) && mem[5] == 32'(wp) && mem[6] == 32'(fill), "R8 descriptor untouched", mem[6], 32'(fill));
      end
    end
  endtask

  initial begin
    int quiet;
    for (int i = 0; i < 16; i++) rq[i] = 0;
    repeat (4) tick();
    rstn = 1;
    quiet = 0;
    repeat (12) begin
      tick();
      if (pReq || reqValid || toValid || fromReady) quiet++;
    end
    chk(quiet == 0, "R1 idle after reset", 32'(quiet), 0);
    for (int d = 0; d < 2; d++)
      for (int r = 0; r < 2; r++)
        for (int f = 0; f < 3; f++)
          runPass(d[0], r * 16, f * 16, 0);
    runPass(1'b1, 0, 16, 1);
    runPass(1'b0, 16, 0, 2);
    runPass(1'b1, 0, 32, 3);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #700000;
    bad++; total++;
    $display("FAIL watchdog expired act=1 exp=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule